// File: doc/BRIEF.md
# RTC Time-Base Divider

This block is the binary countdown chain that sits between a real-time clock's oscillator and its seconds counter. Oscillator cycles arrive as a one-cycle clock-enable on the system clock. The chain divides them down to a one-second update tick, which is a single-cycle pulse. A 3-bit select field is loaded through a simple write port and can be read back. The field sets how many of the leading divider stages are skipped, so that input frequencies of 4.194304 MHz, 1.048576 MHz and 32.768 kHz each give a 1 Hz tick. Some codes of the field stop the chain or hold it cleared.

A static mode input selects a crystal-only variant. In that variant the input is always 32.768 kHz and the chain is 7 stages shorter. The field then only switches the oscillator on or off: bit 0 low runs the chain, and bit 0 high holds it cleared. A write that changes the field restarts the count, so the first tick arrives one full period after that write.

The chain length is the parameter `CHAIN_STAGES`, which defaults to 22. The stage skips of 0, 2 and 7 are fixed. The tick period is therefore 2^(`CHAIN_STAGES` minus the skip) enables, and the crystal-only variant always skips 7 stages.

Top module: `rtc_timebase_div`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0 and `sel_o` reads 3'b010. After reset the count starts from zero.
- R2: In standard mode (`xtal_mode_i`=0), code 3'b000 skips no stages. `tick_o` pulses once every 2^CHAIN_STAGES enabled cycles.
- R3: In standard mode, code 3'b001 skips 2 stages. `tick_o` pulses once every 2^(CHAIN_STAGES-2) enabled cycles.
- R4: In standard mode, code 3'b010 skips 7 stages. `tick_o` pulses once every 2^(CHAIN_STAGES-7) enabled cycles, which is 1 Hz from 32.768 kHz at the default length.
- R5: In standard mode, codes 3'b110 and 3'b111 hold the chain cleared, and no tick is produced.
- R6: In standard mode, codes 3'b011, 3'b100 and 3'b101 stop the chain, and no tick is produced.
- R7: In crystal-only mode (`xtal_mode_i`=1), every code with bit 0 = 0 produces a tick once every 2^(CHAIN_STAGES-7) enabled cycles, whatever bits 2:1 hold.
- R8: In crystal-only mode, every code with bit 0 = 1 holds the chain cleared, and no tick is produced.
- R9: `tick_o` is high for exactly one cycle per wrap. Only cycles with `osc_en_i` high advance the chain.
- R10: A write whose data differs from the current field clears the count on the write edge. The first tick follows exactly one full period later, and a wrap that falls on that same edge is dropped.
- R11: A write of the value already held leaves the count and the tick schedule undisturbed.
- R12: `sel_o` shows the written field from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xtal_mode_i | input | 1 | Static variant select: 0 standard, 1 crystal-only |
| osc_en_i | input | 1 | One-cycle enable per oscillator cycle |
| sel_we_i | input | 1 | Write strobe for the select field |
| sel_wdata_i | input | 3 | Select field write data |
| sel_o | output | 3 | Current select field |
| tick_o | output | 1 | One-second update pulse, one cycle wide |

## Verification
A write that changes the select field and a chain wrap can fall on the same clock edge. The bench provokes this by timing a field change so that its write edge lands exactly on the edge where the scoreboard expects the next tick. On that edge the clear must win: the tick scheduled there is removed from the expected queue. The next tick is then expected one full period of the new code after the write edge, and any pulse on the colliding edge is reported as unexpected. A write of the unchanged value is made while ticks are running, and the previously built schedule must survive it without a shift.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

  typedef logic [2:0] dv_sel_t;

  localparam dv_sel_t SEL_FAST  = 3'b000;
  localparam dv_sel_t SEL_MID   = 3'b001;
  localparam dv_sel_t SEL_SLOW  = 3'b010;
  localparam dv_sel_t SEL_HOLDA = 3'b110;
  localparam dv_sel_t SEL_HOLDB = 3'b111;

  localparam int SKIP_FAST = 0;
  localparam int SKIP_MID  = 2;
  localparam int SKIP_SLOW = 7;

  typedef enum logic [1:0] {
    CH_RUN  = 2'd0,
    CH_STOP = 2'd1,
    CH_HOLD = 2'd2
  } chain_cmd_e;

endpackage

// File: rtl/rtc_div_decode.sv
module rtc_div_decode
  import rtc_div_pkg::*;
#(
  parameter int CHAIN_STAGES = 22,
  parameter int LEN_W        = $clog2(CHAIN_STAGES + 1)
) (
  input  logic             xtal_mode_i,
  input  dv_sel_t          sel_i,
  output chain_cmd_e       cmd_o,
  output logic [LEN_W-1:0] len_o
);

  localparam logic [LEN_W-1:0] LEN_FAST = LEN_W'(CHAIN_STAGES - SKIP_FAST);
  localparam logic [LEN_W-1:0] LEN_MID  = LEN_W'(CHAIN_STAGES - SKIP_MID);
  localparam logic [LEN_W-1:0] LEN_SLOW = LEN_W'(CHAIN_STAGES - SKIP_SLOW);

  always_comb begin
    cmd_o = CH_STOP;
    len_o = LEN_SLOW;
    if (xtal_mode_i) begin
      // crystal-only: bit 0 is the oscillator-off / chain-reset control
      cmd_o = sel_i[0] ? CH_HOLD : CH_RUN;
    end else begin
      unique case (sel_i)
        SEL_FAST: begin cmd_o = CH_RUN; len_o = LEN_FAST; end
        SEL_MID:  begin cmd_o = CH_RUN; len_o = LEN_MID;  end
        SEL_SLOW: begin cmd_o = CH_RUN; len_o = LEN_SLOW; end
        SEL_HOLDA, SEL_HOLDB: cmd_o = CH_HOLD;
        default:  cmd_o = CH_STOP;  // test codes
      endcase
    end
  end

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_div_pkg::*;
#(
  parameter int CHAIN_STAGES = 22,
  parameter int LEN_W        = $clog2(CHAIN_STAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_en_i,
  input  logic             clr_i,
  input  chain_cmd_e       cmd_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             tick_o
);

  logic [CHAIN_STAGES-1:0] cnt_q;
  logic [CHAIN_STAGES-1:0] act_mask;
  logic                    tick_q;
  logic                    wrap;

  // stage g is live when it lies inside the active (non-skipped) length
  for (genvar g = 0; g < CHAIN_STAGES; g++) begin : g_stage
    assign act_mask[g] = (LEN_W'(g) < len_i);
  end

  assign wrap = ((cnt_q & act_mask) == act_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (clr_i || cmd_i == CH_HOLD) begin
        cnt_q <= '0;  // clear beats a coincident wrap
      end else if (cmd_i == CH_RUN && osc_en_i) begin
        if (wrap) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= (cnt_q + CHAIN_STAGES'(1)) & act_mask;
        end
      end
    end
  end

  assign tick_o = tick_q;

  AST_HOLD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CH_HOLD) |=> (cnt_q == '0)); // R5
  AST_STOP_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CH_STOP && !clr_i) |=> $stable(cnt_q)); // R6
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q); // R9
  AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> $past(osc_en_i && cmd_i == CH_RUN && !clr_i)); // R9

endmodule

// File: rtl/rtc_timebase_div.sv
module rtc_timebase_div
  import rtc_div_pkg::*;
#(
  parameter int CHAIN_STAGES = 22
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       xtal_mode_i,
  input  logic       osc_en_i,
  input  logic       sel_we_i,
  input  logic [2:0] sel_wdata_i,
  output logic [2:0] sel_o,
  output logic       tick_o
);

  localparam int LEN_W = $clog2(CHAIN_STAGES + 1);

  dv_sel_t          sel_q;
  logic             sel_chg;
  chain_cmd_e       cmd;
  logic [LEN_W-1:0] len;
  logic             tick_legal;

  assign sel_chg = sel_we_i && (sel_wdata_i != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SEL_SLOW;
    else if (sel_we_i) sel_q <= sel_wdata_i;
  end

  rtc_div_decode #(
    .CHAIN_STAGES(CHAIN_STAGES),
    .LEN_W       (LEN_W)
  ) u_decode (
    .xtal_mode_i(xtal_mode_i),
    .sel_i      (sel_q),
    .cmd_o      (cmd),
    .len_o      (len)
  );

  rtc_div_chain #(
    .CHAIN_STAGES(CHAIN_STAGES),
    .LEN_W       (LEN_W)
  ) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .osc_en_i(osc_en_i),
    .clr_i   (sel_chg),
    .cmd_i   (cmd),
    .len_i   (len),
    .tick_o  (tick_o)
  );

  assign sel_o = sel_q;

  // field codes that may produce a tick, written independently of the decoder
  assign tick_legal = xtal_mode_i ? !sel_q[0]
                                  : (sel_q == 3'b000 || sel_q == 3'b001 || sel_q == 3'b010);

  AST_CHANGE_DROPS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg |=> !tick_o); // R10
  AST_SILENT_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(tick_legal)); // R8
  AST_WRITE_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> (sel_o == $past(sel_wdata_i))); // R12

endmodule

// File: tb/tb_rtc_timebase_div.sv
module tb_rtc_timebase_div;

  localparam int C = 12;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       xtal = 1'b0;
  logic       osc_en = 1'b0;
  logic       we = 1'b0;
  logic [2:0] wdata = 3'b000;
  logic [2:0] sel_o;
  logic       tick_o;

  rtc_timebase_div #(.CHAIN_STAGES(C)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .xtal_mode_i(xtal),
    .osc_en_i   (osc_en),
    .sel_we_i   (we),
    .sel_wdata_i(wdata),
    .sel_o      (sel_o),
    .tick_o     (tick_o)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int osc_div = 1;
  always @(negedge clk) osc_en <= ((cyc % osc_div) == 0);

  int         exp_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  int         n_ticks = 0;
  string      req = "R1";
  logic [2:0] m_sel = 3'b010;
  bit         done = 1'b0;

  function automatic int period_of(logic xm, logic [2:0] s);
    if (xm) return s[0] ? 0 : (1 << (C - 7));
    case (s)
      3'b000:  return 1 << C;
      3'b001:  return 1 << (C - 2);
      3'b010:  return 1 << (C - 7);
      default: return 0;
    endcase
  endfunction

  // driver side: push expected tick edges counted from anchor edge a
  task automatic sched(int a);
    int p;
    int k;
    p = period_of(xtal, m_sel);
    k = 0;
    if (p == 0) return;
    for (int n = a + 1; n <= a + 40000; n++) begin
      if (((n - 1) % osc_div) == 0) begin
        k++;
        if (k == p) begin
          exp_q.push_back(n);
          k = 0;
        end
      end
    end
  endtask

  task automatic chk(bit ok, string r, string what, int act, int ex);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", r, what, act, ex);
    end
  endtask

  // monitor: pop and compare as ticks appear
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        n_cmp++;
        n_bad++;
        $display("FAIL %s: missing tick actual=none expected=%0d", req, exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (tick_o) begin
        n_ticks++;
        n_cmp++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front());
        end else begin
          n_bad++;
          $display("FAIL %s: unexpected tick actual=%0d expected=%0d", req, cyc,
                   (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end
    end
  end

  task automatic wr(logic [2:0] v, int div);
    @(negedge clk);
    osc_div = div;
    we      = 1'b1;
    wdata   = v;
    if (v !== m_sel) begin
      int cw;
      cw = cyc + 1;
      while (exp_q.size() > 0 && exp_q[$] >= cw) void'(exp_q.pop_back());
      m_sel = v;
      sched(cw);
    end
    @(negedge clk);
    we = 1'b0;
    chk(sel_o == v, "R12", "sel_o readback", sel_o, v);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic silent(logic [2:0] v, string r);
    int t0;
    req = r;
    wr(v, 1);
    t0 = n_ticks;
    idle(200);
    chk(n_ticks == t0, r, "ticks in silent code", n_ticks - t0, 0);
  endtask

  task automatic do_reset(logic xm);
    @(negedge clk);
    rst_ni  = 1'b0;
    xtal    = xm;
    we      = 1'b0;
    osc_div = 1;
    exp_q.delete();
    m_sel = 3'b010;
    repeat (3) @(negedge clk);
    chk(tick_o == 1'b0, "R1", "tick_o in reset", tick_o, 0);
    chk(sel_o == 3'b010, "R1", "sel_o in reset", sel_o, 3'b010);
    rst_ni = 1'b1;
    sched(cyc);
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run hung actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // standard mode, reset default code
    do_reset(1'b0);
    req = "R4";
    idle(32 * 4 + 10);
    req = "R11";
    wr(3'b010, 1);
    idle(100);
    // R10: land a field change exactly on a scheduled tick edge
    req = "R10";
    while (cyc != exp_q[0] - 2) @(negedge clk);
    wr(3'b000, 1);
    req = "R2";
    idle((1 << C) * 2 + 20);
    // R3 with a sparse enable; R9 single pulses counted only on enables
    req = "R3 R9";
    wr(3'b001, 3);
    idle((1 << (C - 2)) * 3 * 2 + 20);
    silent(3'b110, "R5");
    silent(3'b111, "R5");
    silent(3'b011, "R6");
    silent(3'b100, "R6");
    silent(3'b101, "R6");
    req = "R4";
    wr(3'b010, 1);
    idle(100);
    // crystal-only variant
    do_reset(1'b1);
    req = "R7";
    idle(100);
    wr(3'b100, 1);
    idle(100);
    wr(3'b000, 2);
    idle(200);
    wr(3'b110, 1);
    idle(100);
    silent(3'b001, "R8");
    silent(3'b011, "R8");
    silent(3'b101, "R8");
    silent(3'b111, "R8");
    req = "R7";
    wr(3'b010, 1);
    idle(100);
    idle(2);
    done = 1'b1;
    foreach (exp_q[i]) begin
      if (exp_q[i] <= cyc) begin
        n_cmp++;
        n_bad++;
        $display("FAIL %s: missing tick actual=none expected=%0d", req, exp_q[i]);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule